// File: doc/BRIEF.md
# Byte-Sliced Bidirectional Latched Transceiver

This block joins an A port and a B port through a 16-bit non-inverting data path. Traffic in each direction has its own storage bank, so a word travelling from A to B can be parked while a different word travelling from B to A is parked or passed at the same time. The path is cut into two 8-bit byte lanes. Every lane has three active-low controls for each direction: an enable, a capture control and a drive control. The two lanes can be run independently, or their controls can be tied together for plain 16-bit use.

Both ports are modelled as an input vector, an output vector and a per-bit drive-enable vector. A drive-enable bit of 0 stands for the high-impedance state. For each lane and direction, the data presented is either the live input of the opposite port (real-time transfer) or the word held in that direction's bank (stored transfer). Storage is sampled on the rising clock edge. A synchronous active-low reset clears both banks, because the storage otherwise comes up unknown.

Top module: `dual_bank_xcvr`

## Requirements
- R1: The data path is non-inverting: every bit presented on an output equals the matching bit of the live input or of the stored word, never its complement, across all 16 bits.
- R2: The two banks are separate: captures in the B-to-A direction leave the A-to-B bank unchanged, and the reverse also holds.
- R3: At a rising clock edge where a lane's enable and capture control for a direction are both 0, that lane's bank takes the lane's input from the source port.
- R4: At a rising edge where a lane's enable is 1 or its capture control is 1, that lane's bank in that direction keeps its value.
- R5: While a lane's enable and capture control are both 0, that lane's output value on the destination port equals the live source input in the same cycle (real-time path).
- R6: The eight drive-enable bits of a lane on a destination port are all 1 exactly when that direction's enable and drive control for the lane are both 0, and are all 0 otherwise.
- R7: While a lane is not in the real-time condition, its output value on the destination port equals the word held in that direction's bank.
- R8: The controls of one lane have no effect on the other lane's output values, drive-enables or storage. One lane can drive A to B while the other drives B to A.
- R9: With the lower-lane and upper-lane controls tied together, the block captures, holds and presents a full 16-bit word.
- R10: At a rising edge with rst_n at 0, both banks become all zeros.
- R11: The environment never has both directions driving the same lane at once. Across all 16 bits, a_oe and b_oe are never 1 on the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of both banks |
| a_in | input | 16 | Value seen on the A lines (source for A-to-B) |
| a_out | output | 16 | Value offered to the A lines (B-to-A path) |
| a_oe | output | 16 | Per-bit drive enable for the A lines; 0 means high impedance |
| b_in | input | 16 | Value seen on the B lines (source for B-to-A) |
| b_out | output | 16 | Value offered to the B lines (A-to-B path) |
| b_oe | output | 16 | Per-bit drive enable for the B lines; 0 means high impedance |
| ab_en_n | input | 2 | A-to-B enable per lane, active low (bit 0 = bits 7:0) |
| ab_le_n | input | 2 | A-to-B capture control per lane, active low |
| ab_oe_n | input | 2 | A-to-B drive control per lane, active low |
| ba_en_n | input | 2 | B-to-A enable per lane, active low |
| ba_le_n | input | 2 | B-to-A capture control per lane, active low |
| ba_oe_n | input | 2 | B-to-A drive control per lane, active low |

## Verification
The contention property assumes the surrounding logic never enables both directions' drives on the same lane in one cycle. That property only checks the inputs, not the design. The sweep walks every combination of the twelve control bits, and whenever a combination would have both directions drive a lane, it raises that lane's B-to-A drive control before applying it. The other properties assume that controls and data change only away from the rising edge. The stimulus does this by driving all inputs just after the falling edge.

// File: rtl/bxl_pkg.sv
// Package: shared types for the byte-sliced transceiver.
// Assumes: nothing beyond IEEE 1800-2017 packed enums.
package bxl_pkg;

    // Operating condition of one lane in one direction
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,   // enable inactive: storage frozen
        MODE_PASS = 2'd1,   // enable and capture active: real-time path
        MODE_HOLD = 2'd2    // enable active, capture inactive: stored path
    } lane_mode_e;

endpackage

// File: rtl/bxl_lane.sv
// Module: one byte lane of one direction.
// Holds an edge-sampled storage word, selects live or stored data for the
// destination port and produces the lane's drive request.
// Assumes: controls are active low and stable around the rising clock edge.
module bxl_lane
    import bxl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              le_n,
    input  logic              oe_n,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              drive
);

    lane_mode_e        mode;
    logic [LANE_W-1:0] q;

    // Decode the lane's operating condition from its controls
    always_comb begin
        if (en_n)
            mode = MODE_OFF;
        else if (!le_n)
            mode = MODE_PASS;
        else
            mode = MODE_HOLD;
    end

    // Storage: cleared by reset, loaded while in the real-time condition
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (mode == MODE_PASS)
            q <= din;
    end

    // Output value: live input on the real-time path, stored word otherwise
    always_comb dout = (mode == MODE_PASS) ? din : q;

    // Drive request: both enable and drive control active
    always_comb drive = !en_n && !oe_n;

    // R3: an active capture stores the source data seen at that edge
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !le_n) |=> (q == $past(din)));

    // R4: without an active capture the stored word keeps its value
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (en_n || le_n)) |=> $stable(q));

    // R5: in the real-time condition the destination sees the live input
    assert_realtime_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !le_n) |-> (dout == din));

    // R7: outside the real-time condition the destination sees storage
    assert_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n || le_n) |-> (dout == q));

endmodule

// File: rtl/bxl_bank.sv
// Module: all byte lanes of one transfer direction.
// Slices the source word into lanes and widens each lane's drive request to
// a per-bit drive-enable vector for the destination port.
// Assumes: LANES * LANE_W equals the port width.
module bxl_bank #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] en_n,
    input  logic [LANES-1:0] le_n,
    input  logic [LANES-1:0] oe_n,
    input  logic [W-1:0]     src,
    output logic [W-1:0]     dst,
    output logic [W-1:0]     dst_oe
);

    logic [LANES-1:0] drv;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bxl_lane #(.LANE_W(LANE_W)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en_n  (en_n[k]),
            .le_n  (le_n[k]),
            .oe_n  (oe_n[k]),
            .din   (src[k*LANE_W +: LANE_W]),
            .dout  (dst[k*LANE_W +: LANE_W]),
            .drive (drv[k])
        );

        // Widen the lane's drive request to every bit of the lane
        always_comb dst_oe[k*LANE_W +: LANE_W] = {LANE_W{drv[k]}};
    end

endmodule

// File: rtl/dual_bank_xcvr.sv
// Module: top of the byte-sliced bidirectional latched transceiver.
// One bank carries A-to-B traffic and a second bank carries B-to-A traffic;
// each byte lane has its own active-low enable, capture and drive controls
// per direction. Ports are split into input, output and drive-enable
// vectors; a drive-enable of 0 stands for high impedance.
// Assumes: the environment never enables both directions on one lane.
module dual_bank_xcvr #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a_in,
    output logic [W-1:0]     a_out,
    output logic [W-1:0]     a_oe,
    input  logic [W-1:0]     b_in,
    output logic [W-1:0]     b_out,
    output logic [W-1:0]     b_oe,
    input  logic [LANES-1:0] ab_en_n,
    input  logic [LANES-1:0] ab_le_n,
    input  logic [LANES-1:0] ab_oe_n,
    input  logic [LANES-1:0] ba_en_n,
    input  logic [LANES-1:0] ba_le_n,
    input  logic [LANES-1:0] ba_oe_n
);

    // A-to-B direction: sources the A lines, presents on the B lines
    bxl_bank #(.LANE_W(LANE_W), .LANES(LANES)) i_bank_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (ab_en_n),
        .le_n   (ab_le_n),
        .oe_n   (ab_oe_n),
        .src    (a_in),
        .dst    (b_out),
        .dst_oe (b_oe)
    );

    // B-to-A direction: sources the B lines, presents on the A lines
    bxl_bank #(.LANE_W(LANE_W), .LANES(LANES)) i_bank_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (ba_en_n),
        .le_n   (ba_le_n),
        .oe_n   (ba_oe_n),
        .src    (b_in),
        .dst    (a_out),
        .dst_oe (a_oe)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R6: B lines driven in a lane only when A-to-B enable and drive are active
        assert_b_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_en_n[k] || ab_oe_n[k]) |-> (b_oe[k*LANE_W +: LANE_W] == '0));
        assert_b_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_en_n[k] && !ab_oe_n[k]) |-> (&b_oe[k*LANE_W +: LANE_W]));
        // R6: A lines driven in a lane only when B-to-A enable and drive are active
        assert_a_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_en_n[k] || ba_oe_n[k]) |-> (a_oe[k*LANE_W +: LANE_W] == '0));
    end

    // R11: the two directions never drive the same bit together
    assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_oe & b_oe) == '0));

endmodule

// File: tb/test_dual_bank_xcvr.sv
`timescale 1ns/1ps
// Bench: walks every combination of the per-lane controls against a
// behavioural model, then runs directed sequences for reset, non-inversion,
// bank separation, tied-lane operation and mixed-direction lanes.
module test_dual_bank_xcvr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, a_oe, b_out, b_oe;
    logic [1:0]  ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
    logic [1:0]  ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;

    int n_cmp = 0, n_bad = 0, n_avoid = 0;
    bit model_ok = 1'b0;
    logic [7:0] m_ab [2];
    logic [7:0] m_ba [2];

    always #2.5 clk = ~clk;

    dual_bank_xcvr i_dual_bank_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Lane field order: {ba_oe, ba_le, ba_en, ab_oe, ab_le, ab_en}, lane 0 in bits 5:0
    task automatic apply(input logic [11:0] c, input logic [15:0] a, input logic [15:0] b, input logic rst);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            ab_en_n[k] = c[6*k];   ab_le_n[k] = c[6*k+1]; ab_oe_n[k] = c[6*k+2];
            ba_en_n[k] = c[6*k+3]; ba_le_n[k] = c[6*k+4]; ba_oe_n[k] = c[6*k+5];
            // R11: never let both directions drive one lane; flag and back off
            if (!ab_en_n[k] && !ab_oe_n[k] && !ba_en_n[k] && !ba_oe_n[k]) begin
                ba_oe_n[k] = 1'b1;
                n_avoid++;
            end
        end
        a_in = a; b_in = b; rst_n = rst;
        #1;
        if (model_ok) begin
            for (int k = 0; k < 2; k++) begin
                logic tr_ab, tr_ba;
                logic [7:0] eb, ea, eob, eoa;
                tr_ab = !ab_en_n[k] && !ab_le_n[k];
                tr_ba = !ba_en_n[k] && !ba_le_n[k];
                eb  = tr_ab ? a_in[8*k +: 8] : m_ab[k];
                ea  = tr_ba ? b_in[8*k +: 8] : m_ba[k];
                eob = (!ab_en_n[k] && !ab_oe_n[k]) ? 8'hFF : 8'h00;
                eoa = (!ba_en_n[k] && !ba_oe_n[k]) ? 8'hFF : 8'h00;
                chk(b_oe[8*k +: 8] == eob, "R6 b_oe", b_oe, {8'h0, eob});
                chk(a_oe[8*k +: 8] == eoa, "R6 a_oe", a_oe, {8'h0, eoa});
                chk(b_out[8*k +: 8] == eb, tr_ab ? "R5 b_out" : "R7 b_out", b_out, {8'h0, eb});
                chk(a_out[8*k +: 8] == ea, tr_ba ? "R5 a_out" : "R7 a_out", a_out, {8'h0, ea});
            end
            chk((a_oe & b_oe) == '0, "R11 contention", a_oe & b_oe, 16'h0);
        end
    endtask

    // Advance one rising edge and update the behavioural banks
    task automatic latch();
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_ab[k] = '0; m_ba[k] = '0;
            end else begin
                if (!ab_en_n[k] && !ab_le_n[k]) m_ab[k] = a_in[8*k +: 8];
                if (!ba_en_n[k] && !ba_le_n[k]) m_ba[k] = b_in[8*k +: 8];
            end
        end
        model_ok = 1'b1;
    endtask

    initial begin
        // R10: reset clears both banks
        apply(12'hFFF, 16'h0, 16'h0, 1'b0); latch();
        apply({2{6'b111010}}, 16'hFFFF, 16'hFFFF, 1'b1);
        chk(b_out == 16'h0000, "R10 ab bank", b_out, 16'h0000);
        chk(b_oe == 16'hFFFF, "R6 full drive", b_oe, 16'hFFFF);
        latch();
        apply({2{6'b010111}}, 16'hFFFF, 16'hFFFF, 1'b1);
        chk(a_out == 16'h0000, "R10 ba bank", a_out, 16'h0000);
        latch();
        // R9 / R5: tied lanes, real-time A-to-B
        apply({2{6'b111000}}, 16'hA55A, 16'h0, 1'b1);
        chk(b_out == 16'hA55A, "R9 R5 tied pass", b_out, 16'hA55A);
        latch();
        // R1 / R4 / R9: hold with the input changed, no complement
        apply({2{6'b111010}}, 16'h0000, 16'h0, 1'b1);
        chk(b_out == 16'hA55A, "R1 R4 R9 tied hold", b_out, 16'hA55A);
        latch();
        // R2: B-to-A capture while A-to-B presents its held word
        apply({2{6'b100010}}, 16'hFFFF, 16'h1234, 1'b1);
        chk(b_out == 16'hA55A, "R2 ab bank kept", b_out, 16'hA55A);
        latch();
        apply({2{6'b010111}}, 16'hFFFF, 16'hFFFF, 1'b1);
        chk(a_out == 16'h1234, "R2 R3 ba bank", a_out, 16'h1234);
        chk(a_oe == 16'hFFFF, "R6 ba drive", a_oe, 16'hFFFF);
        latch();
        // R8: lane 0 drives A-to-B while lane 1 drives B-to-A
        apply({6'b010111, 6'b111010}, 16'h0, 16'h0, 1'b1);
        chk(b_oe == 16'h00FF, "R8 b_oe", b_oe, 16'h00FF);
        chk(a_oe == 16'hFF00, "R8 a_oe", a_oe, 16'hFF00);
        chk(b_out[7:0] == 8'h5A, "R8 lane0 ab", {8'h0, b_out[7:0]}, 16'h005A);
        chk(a_out[15:8] == 8'h12, "R8 lane1 ba", {8'h0, a_out[15:8]}, 16'h0012);
        latch();
        // R3 R4 R5 R6 R7 R8: exhaustive sweep over all control combinations
        for (int s = 0; s < 4096; s++) begin
            logic [15:0] av, bv;
            av = 16'(s * 16'h9E37) ^ 16'h5A3C;
            bv = ~16'(s * 16'h3B1D);
            apply(12'(s), av, bv, 1'b1);
            latch();
        end
        $display("contention combinations backed off (R11): %0d", n_avoid);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule